// File: doc/BRIEF.md
# Memory LCD Serial Command Transmitter

This block drives a write-only monochrome memory LCD over a three-wire serial link made up of a chip select, a serial clock and a data line. A host issues one of four requests: refresh a single line, refresh a burst of lines, blank the whole panel, or send only the polarity bit that keeps the panel's common electrode alternating. For line refreshes the block takes line addresses and pixel bytes from the host through two ready/valid streams. It then emits the command, address, pixel and trailer fields in the order the panel expects.

The serial clock comes from a half-period divider on the system clock. Data changes only while the serial clock is low, so every rising edge finds it settled. The horizontal resolution is a parameter and must be a multiple of eight. Each pixel byte carries eight horizontally adjacent pixels, with bit 0 being the leftmost.

Top module: `memlcd_cmd_tx`

## Requirements
- R1: After reset, and between transactions, `lcd_cs`, `lcd_sclk`, `lcd_sdata` and `busy` are all low.
- R2: `lcd_cs` rises once per accepted request and stays high for the whole transaction. It falls only after the last trailer bit's rising edge plus one further low half-period. `lcd_sclk` is high only while `lcd_cs` is high.
- R3: Each high phase of `lcd_sclk` lasts exactly HALF_DIV system clocks, and each low phase lasts at least HALF_DIV. `lcd_sdata` never changes while `lcd_sclk` is high.
- R4: Every field goes out least-significant bit first. Pixel bytes go out in the order they were accepted, and bit 0 of each byte is the leftmost pixel.
- R5: `req_op` encodes 00 as polarity-only, 01 as single line, 10 as burst and 11 as clear. The first eight bits sent, in time order, are: 1,V,0,0,0,0,0,0 for either line write; 0,V,1,0,0,0,0,0 for clear; and 0,V,0,0,0,0,0,0 for polarity-only. V is `req_vcom` as sampled at acceptance.
- R6: A single-line write sends the command, one 8-bit address, H_RES pixel bits and 16 zero bits. The trailer length does not depend on `ln_last`.
- R7: A burst sends the command once, then address and H_RES pixel bits for each line. After each line comes an 8-bit zero trailer, except after the line whose `ln_last` was high when its address was taken, which gets a 16-bit zero trailer and ends the transaction.
- R8: Clear and polarity-only requests send the command byte and 8 zero bits. They perform no handshake on the line or pixel stream.
- R9: `busy` is high in the cycle after a request is accepted and stays high while `lcd_cs` is high. It falls in the same cycle as `lcd_cs`.
- R10: A request presented while `busy` is high is ignored. The current transaction's bit stream is unchanged, and no second transaction follows it.
- R11: When the pixel stream stalls, `lcd_sclk` is held low and the bit stream resumes unchanged once data arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_op | input | 2 | Request kind (00 polarity, 01 line, 10 burst, 11 clear) |
| req_vcom | input | 1 | Polarity bit placed in the command byte |
| busy | output | 1 | Transaction in progress |
| ln_valid | input | 1 | Line address available |
| ln_ready | output | 1 | Line address taken this cycle when valid |
| ln_addr | input | 8 | Panel line address |
| ln_last | input | 1 | Marks the final line of a burst |
| pix_valid | input | 1 | Pixel byte available |
| pix_ready | output | 1 | Pixel byte taken this cycle when valid |
| pix_data | input | 8 | Eight pixels, bit 0 leftmost |
| lcd_cs | output | 1 | Panel chip select, active high |
| lcd_sclk | output | 1 | Panel serial clock, idle low |
| lcd_sdata | output | 1 | Panel serial data |

## Verification
A framer state that slips by one field shows up within one byte time on `lcd_sdata`: the bit captured at the next rising `lcd_sclk` edge no longer matches the expected command, address, pixel or trailer bit. A bad trailer count or a lost last-line flag changes the number of rising edges before `lcd_cs` falls. That is visible when the transaction closes, and also at the `busy` release, which must coincide with the fall of `lcd_cs`. Divider or serializer faults appear within one bit period as a wrong high-phase length or as data that moves while the clock is high.

// File: rtl/memlcd_pkg.sv
// Shared types for the memory LCD command transmitter.
// Assumes the panel takes an 8-bit command with the polarity bit second in time.
package memlcd_pkg;

    typedef enum logic [1:0] {
        OP_VCOM  = 2'b00,
        OP_LINE  = 2'b01,
        OP_BURST = 2'b10,
        OP_CLEAR = 2'b11
    } memlcd_op_e;

    // Command byte in shift-register order: bit 0 leaves the block first.
    function automatic logic [7:0] cmd_byte(input memlcd_op_e op, input logic vcom);
        logic [7:0] b;
        case (op)
            OP_LINE, OP_BURST: b = {6'b000000, vcom, 1'b1};
            OP_CLEAR:          b = {5'b00000, 1'b1, vcom, 1'b0};
            default:           b = {6'b000000, vcom, 1'b0};
        endcase
        return b;
    endfunction

    function automatic logic op_writes_lines(input memlcd_op_e op);
        return (op == OP_LINE) || (op == OP_BURST);
    endfunction

endpackage

// File: rtl/memlcd_clkdiv.sv
// Half-period tick generator for the serial clock.
// Counts system clocks while run is high and pulses half_tick on the last
// count of every half period. Restarts from zero whenever run drops.
module memlcd_clkdiv #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic half_tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] TOP = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;

    assign half_tick = run && (cnt == TOP);

    // Count the current half period, cleared while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || (cnt == TOP)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        half_tick |-> run);  // R3

endmodule

// File: rtl/memlcd_serializer.sv
// Byte-to-bit serializer for the panel link.
// Takes bytes over a valid/ready hand-off, shifts each out LSB first, holds
// chip select across bytes and closes with one low half period after the byte
// flagged last. Assumes the byte source keeps valid steady until accepted.
module memlcd_serializer #(
    parameter int HALF_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_valid,
    input  logic [7:0] byte_data,
    input  logic       byte_last,
    output logic       byte_ready,
    output logic       done,
    output logic       scs,
    output logic       sclk,
    output logic       sdata
);
    typedef enum logic [2:0] {
        SER_IDLE, SER_FETCH, SER_LOW, SER_HIGH, SER_TAIL
    } ser_state_e;

    ser_state_e state;
    logic [7:0] shreg;
    logic [2:0] bit_idx;
    logic       last_q;
    logic       half_tick;
    logic       run;

    assign run        = (state == SER_LOW) || (state == SER_HIGH) || (state == SER_TAIL);
    assign byte_ready = (state == SER_IDLE) || (state == SER_FETCH);
    assign done       = (state == SER_TAIL) && half_tick;

    memlcd_clkdiv #(.HALF_DIV(HALF_DIV)) div_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .half_tick (half_tick)
    );

    // Walk each byte through low/high clock phases and frame it with chip select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SER_IDLE;
            shreg   <= '0;
            bit_idx <= '0;
            last_q  <= 1'b0;
            scs     <= 1'b0;
            sclk    <= 1'b0;
            sdata   <= 1'b0;
        end else begin
            case (state)
                SER_IDLE, SER_FETCH: begin
                    if (byte_valid) begin
                        shreg   <= byte_data;
                        sdata   <= byte_data[0];
                        last_q  <= byte_last;
                        bit_idx <= '0;
                        scs     <= 1'b1;
                        state   <= SER_LOW;
                    end
                end
                SER_LOW: begin
                    if (half_tick) begin
                        sclk  <= 1'b1;
                        state <= SER_HIGH;
                    end
                end
                SER_HIGH: begin
                    if (half_tick) begin
                        sclk <= 1'b0;
                        if (bit_idx == 3'd7) begin
                            if (last_q) begin
                                sdata <= 1'b0;
                                state <= SER_TAIL;
                            end else begin
                                state <= SER_FETCH;
                            end
                        end else begin
                            bit_idx <= bit_idx + 3'd1;
                            shreg   <= {1'b0, shreg[7:1]};
                            sdata   <= shreg[1];
                            state   <= SER_LOW;
                        end
                    end
                end
                SER_TAIL: begin
                    if (half_tick) begin
                        scs   <= 1'b0;
                        state <= SER_IDLE;
                    end
                end
                default: state <= SER_IDLE;
            endcase
        end
    end

    AST_SCLK_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> scs);  // R2
    AST_CS_DROP_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scs) |-> (!sclk && !sdata));  // R2
    AST_DATA_STEADY_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $stable(sdata));  // R3
    AST_DATA_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(sdata));  // R3
    AST_FETCH_STALL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SER_FETCH) |-> (!sclk && scs));  // R11

endmodule

// File: rtl/memlcd_framer.sv
// Transaction sequencer for the panel protocol.
// Accepts one host request at a time and offers the serializer a byte stream:
// command, then per line address, pixel bytes and a one- or two-byte zero
// trailer. Assumes H_RES is a multiple of 8.
module memlcd_framer
    import memlcd_pkg::*;
#(
    parameter int H_RES = 400
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [1:0] req_op,
    input  logic       req_vcom,
    output logic       busy,
    input  logic       ln_valid,
    output logic       ln_ready,
    input  logic [7:0] ln_addr,
    input  logic       ln_last,
    input  logic       pix_valid,
    output logic       pix_ready,
    input  logic [7:0] pix_data,
    output logic       byte_valid,
    output logic [7:0] byte_data,
    output logic       byte_last,
    input  logic       byte_ready,
    input  logic       ser_done
);
    localparam int BPL = H_RES / 8;
    localparam int PCW = (BPL > 1) ? $clog2(BPL) : 1;
    localparam logic [PCW-1:0] PIX_TOP = PCW'(BPL - 1);

    typedef enum logic [2:0] {
        FR_IDLE, FR_CMD, FR_ADDR, FR_DATA, FR_TRAIL, FR_DRAIN
    } fr_state_e;

    fr_state_e  state;
    memlcd_op_e op_q;
    logic       vcom_q;
    logic       last_line_q;
    logic       end_q;
    logic [1:0] trail_cnt;
    logic [PCW-1:0] pix_cnt;
    logic       fire;

    assign busy = (state != FR_IDLE);
    assign fire = byte_valid && byte_ready;

    // Pick the byte offered to the serializer from the current field.
    always_comb begin
        byte_valid = 1'b0;
        byte_data  = 8'h00;
        byte_last  = 1'b0;
        ln_ready   = 1'b0;
        pix_ready  = 1'b0;
        case (state)
            FR_CMD: begin
                byte_valid = 1'b1;
                byte_data  = cmd_byte(op_q, vcom_q);
            end
            FR_ADDR: begin
                byte_valid = ln_valid;
                byte_data  = ln_addr;
                ln_ready   = byte_ready;
            end
            FR_DATA: begin
                byte_valid = pix_valid;
                byte_data  = pix_data;
                pix_ready  = byte_ready;
            end
            FR_TRAIL: begin
                byte_valid = 1'b1;
                byte_last  = end_q && (trail_cnt == 2'd1);
            end
            default: ;
        endcase
    end

    // Advance through the fields of one transaction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= FR_IDLE;
            op_q        <= OP_VCOM;
            vcom_q      <= 1'b0;
            last_line_q <= 1'b0;
            end_q       <= 1'b0;
            trail_cnt   <= 2'd0;
            pix_cnt     <= '0;
        end else begin
            case (state)
                FR_IDLE: begin
                    if (req_valid) begin
                        op_q   <= memlcd_op_e'(req_op);
                        vcom_q <= req_vcom;
                        state  <= FR_CMD;
                    end
                end
                FR_CMD: begin
                    if (fire) begin
                        if (op_writes_lines(op_q)) begin
                            state <= FR_ADDR;
                        end else begin
                            trail_cnt <= 2'd1;
                            end_q     <= 1'b1;
                            state     <= FR_TRAIL;
                        end
                    end
                end
                FR_ADDR: begin
                    if (fire) begin
                        last_line_q <= (op_q == OP_LINE) || ln_last;
                        pix_cnt     <= '0;
                        state       <= FR_DATA;
                    end
                end
                FR_DATA: begin
                    if (fire) begin
                        if (pix_cnt == PIX_TOP) begin
                            trail_cnt <= last_line_q ? 2'd2 : 2'd1;
                            end_q     <= last_line_q;
                            state     <= FR_TRAIL;
                        end else begin
                            pix_cnt <= pix_cnt + 1'b1;
                        end
                    end
                end
                FR_TRAIL: begin
                    if (fire) begin
                        if (trail_cnt == 2'd1) begin
                            state <= end_q ? FR_DRAIN : FR_ADDR;
                        end
                        trail_cnt <= trail_cnt - 2'd1;
                    end
                end
                FR_DRAIN: begin
                    if (ser_done) begin
                        state <= FR_IDLE;
                    end
                end
                default: state <= FR_IDLE;
            endcase
        end
    end

    AST_REQ_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid) |=> ($stable(op_q) && $stable(vcom_q)));  // R10
    AST_PIX_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pix_cnt <= PIX_TOP);  // R6
    AST_NO_LINE_HS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        (ln_ready || pix_ready) |-> op_writes_lines(op_q));  // R8
    AST_TRAILER_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FR_TRAIL) |-> (trail_cnt == 2'd1 || trail_cnt == 2'd2));  // R7

endmodule

// File: rtl/memlcd_cmd_tx.sv
// Top of the memory LCD command transmitter.
// Joins the protocol framer to the bit serializer. The host sees a request
// port, two ready/valid streams for line addresses and pixel bytes, and the
// three panel wires. Assumes H_RES is a multiple of 8 and HALF_DIV >= 1.
module memlcd_cmd_tx #(
    parameter int H_RES    = 400,
    parameter int HALF_DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [1:0] req_op,
    input  logic       req_vcom,
    output logic       busy,
    input  logic       ln_valid,
    output logic       ln_ready,
    input  logic [7:0] ln_addr,
    input  logic       ln_last,
    input  logic       pix_valid,
    output logic       pix_ready,
    input  logic [7:0] pix_data,
    output logic       lcd_cs,
    output logic       lcd_sclk,
    output logic       lcd_sdata
);
    logic       byte_valid;
    logic [7:0] byte_data;
    logic       byte_last;
    logic       byte_ready;
    logic       ser_done;

    memlcd_framer #(.H_RES(H_RES)) framer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_op     (req_op),
        .req_vcom   (req_vcom),
        .busy       (busy),
        .ln_valid   (ln_valid),
        .ln_ready   (ln_ready),
        .ln_addr    (ln_addr),
        .ln_last    (ln_last),
        .pix_valid  (pix_valid),
        .pix_ready  (pix_ready),
        .pix_data   (pix_data),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .byte_last  (byte_last),
        .byte_ready (byte_ready),
        .ser_done   (ser_done)
    );

    memlcd_serializer #(.HALF_DIV(HALF_DIV)) ser_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .byte_last  (byte_last),
        .byte_ready (byte_ready),
        .done       (ser_done),
        .scs        (lcd_cs),
        .sclk       (lcd_sclk),
        .sdata      (lcd_sdata)
    );

    AST_CS_WITHIN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_cs |-> busy);  // R9
    AST_BUSY_RELEASE_WITH_CS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $fell(lcd_cs));  // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!lcd_cs && !lcd_sclk));  // R1

endmodule

// File: tb/memlcd_cmd_tx_tb.sv
// Self-checking bench for memlcd_cmd_tx: a vector table walked by one loop,
// then directed tests for ignored requests and reset during a transfer.
module memlcd_cmd_tx_tb_top;
    localparam int H_RES    = 16;
    localparam int HALF_DIV = 3;
    localparam int BPL      = H_RES / 8;
    localparam int MAXB     = 512;
    localparam int NVEC     = 10;

    // Vector layout: [31] stall, [30] ln_last for single line, [29:28] lines,
    // [27] vcom, [26:25] op, [24] inject, [23:16] first address, [7:0] seed.
    localparam logic [31:0] VEC [NVEC] = '{
        {1'b0, 1'b1, 2'd1, 1'b0, 2'b01, 1'b0, 8'd5,   8'h00, 8'hA5},
        {1'b0, 1'b0, 2'd1, 1'b1, 2'b01, 1'b0, 8'd240, 8'h00, 8'h3C},
        {1'b0, 1'b0, 2'd3, 1'b0, 2'b10, 1'b0, 8'd17,  8'h00, 8'h5A},
        {1'b0, 1'b0, 2'd1, 1'b1, 2'b10, 1'b0, 8'd200, 8'h00, 8'hF0},
        {1'b0, 1'b0, 2'd1, 1'b1, 2'b11, 1'b0, 8'd0,   8'h00, 8'h00},
        {1'b0, 1'b0, 2'd1, 1'b0, 2'b11, 1'b0, 8'd0,   8'h00, 8'h00},
        {1'b0, 1'b0, 2'd1, 1'b1, 2'b00, 1'b0, 8'd0,   8'h00, 8'h00},
        {1'b0, 1'b0, 2'd1, 1'b0, 2'b00, 1'b0, 8'd0,   8'h00, 8'h00},
        {1'b1, 1'b0, 2'd2, 1'b1, 2'b10, 1'b0, 8'd2,   8'h00, 8'h81},
        {1'b1, 1'b1, 2'd1, 1'b0, 2'b01, 1'b0, 8'd99,  8'h00, 8'h6E}
    };

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_op = 2'b00;
    logic       req_vcom = 1'b0;
    logic       busy, ln_valid, ln_ready, ln_last, pix_valid, pix_ready;
    logic [7:0] ln_addr, pix_data;
    logic       lcd_cs, lcd_sclk, lcd_sdata;

    memlcd_cmd_tx #(.H_RES(H_RES), .HALF_DIV(HALF_DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_vcom(req_vcom), .busy(busy), .ln_valid(ln_valid), .ln_ready(ln_ready),
        .ln_addr(ln_addr), .ln_last(ln_last), .pix_valid(pix_valid),
        .pix_ready(pix_ready), .pix_data(pix_data), .lcd_cs(lcd_cs),
        .lcd_sclk(lcd_sclk), .lcd_sdata(lcd_sdata)
    );

    int checks = 0;
    int failures = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [7:0] line_addr(input logic [7:0] a0, input int l);
        return 8'(int'(a0) + l * 37);
    endfunction

    function automatic logic [7:0] pix_byte(input logic [7:0] seed, input int k);
        return seed ^ 8'(k * 29 + 1);
    endfunction

    // Host model: line and pixel sources
    logic       host_clr = 1'b1;
    logic       host_en = 1'b0;
    logic [1:0] cur_op = 2'b00;
    int         cur_n = 1;
    logic [7:0] cur_a0 = 8'h00;
    logic [7:0] cur_seed = 8'h00;
    logic       cur_stall = 1'b0;
    logic       cur_lastflag = 1'b0;
    int         addr_idx = 0;
    int         pix_total = 0;
    int         cyc = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (host_clr) begin
            addr_idx  <= 0;
            pix_total <= 0;
        end else begin
            if (ln_valid && ln_ready)   addr_idx  <= addr_idx + 1;
            if (pix_valid && pix_ready) pix_total <= pix_total + 1;
        end
    end

    assign ln_valid  = host_en && (addr_idx < cur_n);
    assign ln_addr   = line_addr(cur_a0, addr_idx);
    assign ln_last   = (addr_idx == cur_n - 1) ? ((cur_op == 2'b01) ? cur_lastflag : 1'b1) : 1'b0;
    assign pix_valid = host_en && (!cur_stall || (cyc % 4 == 3));
    assign pix_data  = pix_byte(cur_seed, pix_total);

    // Link monitor, sampled on the falling system clock edge
    logic cap [MAXB];
    int   cap_n = 0, cs_rises = 0, r2_viol = 0, r3_viol = 0, r9_viol = 0;
    int   hi_run = 0, lo_run = 0;
    logic p_sclk = 1'b0, p_sdata = 1'b0, p_cs = 1'b0;

    always @(negedge clk) begin
        if (host_clr) begin
            cap_n = 0; cs_rises = 0; r2_viol = 0; r3_viol = 0; r9_viol = 0;
        end else begin
            if (lcd_cs && !p_cs) cs_rises++;
            if (lcd_sclk && !p_sclk) begin
                if (cap_n < MAXB) cap[cap_n] = lcd_sdata;
                cap_n++;
                if (lo_run < HALF_DIV) r3_viol++;
            end
            if (lcd_sclk && (lcd_sdata !== p_sdata)) r3_viol++;
            if (!lcd_sclk && p_sclk && hi_run != HALF_DIV) r3_viol++;
            if (lcd_sclk && !lcd_cs) r2_viol++;
            if (!lcd_cs && p_cs && (lcd_sclk || lo_run < HALF_DIV)) r2_viol++;
            if (lcd_cs && !busy) r9_viol++;
            if (!lcd_cs && p_cs && busy) r9_viol++;
        end
        hi_run = lcd_sclk ? hi_run + 1 : 0;
        lo_run = (lcd_cs && !lcd_sclk) ? lo_run + 1 : 0;
        p_sclk = lcd_sclk; p_sdata = lcd_sdata; p_cs = lcd_cs;
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog expired (R9 busy release) actual=%0d expected=%0d", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Expected stream
    logic ebits [MAXB];
    int   e_n = 0;

    task automatic push_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) ebits[e_n + i] = b[i];
        e_n += 8;
    endtask

    function automatic logic [7:0] exp_cmd(input logic [1:0] op, input logic v);
        case (op)
            2'b01, 2'b10: return {6'b0, v, 1'b1};
            2'b11:        return {5'b0, 1'b1, v, 1'b0};
            default:      return {6'b0, v, 1'b0};
        endcase
    endfunction

    task automatic build_exp(input logic [1:0] op, input logic v, input int n,
                             input logic [7:0] a0, input logic [7:0] seed);
        e_n = 0;
        push_byte(exp_cmd(op, v));
        if (op == 2'b01 || op == 2'b10) begin
            for (int l = 0; l < n; l++) begin
                push_byte(line_addr(a0, l));
                for (int b = 0; b < BPL; b++) push_byte(pix_byte(seed, l * BPL + b));
                push_byte(8'h00);
                if (l == n - 1) push_byte(8'h00);
            end
        end else begin
            push_byte(8'h00);
        end
    endtask

    task automatic run_vec(input logic [31:0] v, input bit inject);
        logic [1:0] op;
        logic       vc;
        bit         wr;
        int         w;
        int         bad;
        int         cmd_bad;
        string      ltag;
        op = v[26:25];
        vc = v[27];
        wr = (op == 2'b01) || (op == 2'b10);
        cur_op = op; cur_n = int'(v[29:28]); cur_a0 = v[23:16]; cur_seed = v[7:0];
        cur_stall = v[31]; cur_lastflag = v[30];
        ltag = (op == 2'b01) ? "R6 single-line length" :
               (op == 2'b10) ? "R7 burst length" : "R8 control length";
        build_exp(op, vc, cur_n, cur_a0, cur_seed);
        host_clr = 1'b1; host_en = 1'b0;
        step(); step();
        host_clr = 1'b0; host_en = 1'b1;
        chk(!busy && !lcd_cs && !lcd_sclk && !lcd_sdata, "R1 idle before request",
            {busy, lcd_cs, lcd_sclk, lcd_sdata}, 0);
        req_valid = 1'b1; req_op = op; req_vcom = vc;
        step();
        req_valid = 1'b0;
        chk(busy, "R9 busy after accept", busy, 1);
        if (inject) begin
            repeat (5) step();
            req_valid = 1'b1; req_op = 2'b11; req_vcom = ~vc;
            step();
            req_valid = 1'b0;
        end
        w = 0;
        while (busy && w < 20000) begin
            step();
            w++;
        end
        chk(w < 20000, "R9 busy release", w, 0);
        repeat (4) step();
        chk(cs_rises == 1, "R2 one chip-select frame", cs_rises, 1);
        chk(r2_viol == 0, "R2 clock inside chip select", r2_viol, 0);
        chk(r3_viol == 0, "R3 clock phases and data stability", r3_viol, 0);
        chk(r9_viol == 0, "R9 busy follows chip select", r9_viol, 0);
        chk(cap_n == e_n, ltag, cap_n, e_n);
        cmd_bad = 0;
        for (int i = 0; i < 8; i++) if (i < cap_n && cap[i] !== ebits[i]) cmd_bad++;
        chk(cmd_bad == 0, "R5 command bits", cmd_bad, 0);
        bad = -1;
        for (int i = 0; i < e_n && i < cap_n; i++) begin
            if (bad < 0 && cap[i] !== ebits[i]) bad = i;
        end
        chk(bad < 0, "R4 bit stream order", bad, -1);
        if (cur_stall) chk(bad < 0 && cap_n == e_n, "R11 stalled stream intact", bad, -1);
        chk(addr_idx == (wr ? cur_n : 0), wr ? "R7 address handshakes" : "R8 no address handshake",
            addr_idx, wr ? cur_n : 0);
        chk(pix_total == (wr ? cur_n * BPL : 0), wr ? "R6 pixel handshakes" : "R8 no pixel handshake",
            pix_total, wr ? cur_n * BPL : 0);
        if (inject) begin
            repeat (40) step();
            chk(cs_rises == 1 && !busy && !lcd_cs, "R10 request while busy ignored", cs_rises, 1);
        end
        chk(!busy && !lcd_cs && !lcd_sclk && !lcd_sdata, "R1 idle after transaction",
            {busy, lcd_cs, lcd_sclk, lcd_sdata}, 0);
        host_en = 1'b0;
    endtask

    initial begin
        repeat (3) step();
        chk(!lcd_cs && !lcd_sclk && !lcd_sdata && !busy, "R1 reset state",
            {busy, lcd_cs, lcd_sclk, lcd_sdata}, 0);
        rst_n = 1'b1;
        step();
        chk(!lcd_cs && !lcd_sclk && !busy, "R1 after reset release", {busy, lcd_cs, lcd_sclk}, 0);

        for (int i = 0; i < NVEC; i++) run_vec(VEC[i], 1'b0);

        // R10: a clear request injected during a burst must not disturb it
        run_vec({1'b0, 1'b0, 2'd2, 1'b1, 2'b10, 1'b0, 8'd33, 8'h00, 8'h47}, 1'b1);

        // R1: reset in the middle of a burst returns the link to idle
        cur_op = 2'b10; cur_n = 3; cur_a0 = 8'd9; cur_seed = 8'h12; cur_stall = 1'b0;
        host_clr = 1'b1; step(); host_clr = 1'b0; host_en = 1'b1;
        req_valid = 1'b1; req_op = 2'b10; req_vcom = 1'b0;
        step();
        req_valid = 1'b0;
        repeat (40) step();
        chk(lcd_cs && busy, "R2 frame open mid burst", lcd_cs, 1);
        rst_n = 1'b0;
        step(); step();
        chk(!lcd_cs && !lcd_sclk && !lcd_sdata && !busy, "R1 reset mid transfer",
            {busy, lcd_cs, lcd_sclk, lcd_sdata}, 0);
        rst_n = 1'b1;
        host_en = 1'b0;
        step();
        run_vec(VEC[0], 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule